// File: doc/BRIEF.md
# BCD Time-of-Day Calendar Counter

This block keeps wall-clock time and calendar date as seven packed-BCD byte registers: seconds, minutes, hours, day-of-week, date, month (with a century flag) and year. A base enable pulse is divided by a parameterised count to form one event per second. Each second event advances seconds, and the carries ripple into minutes, hours, the day fields, the month and the year within the same clock edge.

The hours byte carries its own format selector. A set bit 6 means 12-hour form, where bit 5 marks the afternoon. A clear bit 6 means 24-hour form, where bit 5 becomes the upper tens-of-hours bit. The host loads any single register through a one-cycle write port. It reads any register through a combinational read port. Out-of-range values written by the host give undefined results and are not corrected.

Top module: `tod_calendar`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00 (24-hour form), day-of-week 0x01, date 0x01, month byte 0x01 (century flag 0) and year 0x00.
- R2: Seconds and minutes count in BCD from 00 to 59. A second event at 59 seconds gives 00 and advances minutes. Minutes at 59 wrap to 00 and advance the hour.
- R3: In 24-hour form (hours bit 6 = 0), bits 5:0 hold the hour in BCD from 00 to 23. 23:59:59 advances to 00:00:00 and starts a new day.
- R4: In 12-hour form (hours bit 6 = 1), bit 5 is 1 for PM and bits 4:0 hold 1 to 12 in BCD. The hour goes from 11 to 12 with bit 5 inverted, and from 12 to 1 with bit 5 kept. The change from 11 PM to 12 AM starts a new day. Counting never changes bit 6.
- R5: The day-of-week register (values 1 to 7) advances on each new day, and 7 wraps to 1.
- R6: On a new day the date advances, and after the month's last day it returns to 01. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year is divisible by 4, and 28 days otherwise. All other months have 31 days.
- R7: The month byte holds the month 01 to 12 in BCD in bits 4:0 and the century flag in bit 7. On a date rollover, month 12 returns to 01 and advances the year. Year 99 returns to 00 and inverts the century flag.
- R8: One second event occurs on every TICKS_PER_SEC-th `tick_i` pulse. Without a write or a second event the registers hold their values. A write to seconds restarts the pulse count.
- R9: While `wr_en_i` is high, the register at `wr_addr_i` takes `wr_data_i` at the clock edge, and no field advances in that cycle. Addresses: 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 date, 5 month, 6 year. Bits that are stored: seconds and minutes 6:0, hours 6:0, day-of-week 2:0, date 5:0, month 7 and 4:0, year 7:0. All other bits read 0. A write to address 7 changes nothing.
- R10: `rd_data_o` shows the register at `rd_addr_i` combinationally, using the address map of R9. Address 7 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base enable pulse, divided to seconds |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address for the write |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Register address for the read |
| rd_data_o | output | 8 | Selected register contents |

## Verification
The bench builds the block with TICKS_PER_SEC = 3. With that value, tick pulses that do not complete a second can be seen as having no effect. It also lets the divider restart on a seconds write be told apart from a free-running count. Second events can also coincide with host writes at varied phases. Directed loads reach the boundaries of 24-hour and 12-hour midnight, the noon crossing, every month length, leap and common February, and the year 99 wrap. Random ticks and legal random writes then run against a binary reference model.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
    localparam logic [ADDR_W-1:0] A_DOW  = 3'd3;
    localparam logic [ADDR_W-1:0] A_DATE = 3'd4;
    localparam logic [ADDR_W-1:0] A_MON  = 3'd5;
    localparam logic [ADDR_W-1:0] A_YEAR = 3'd6;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] mon;
        logic [7:0] year;
    } tod_regs_t;

    // Increment a two-digit packed BCD value (no wrap handling here).
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // Year divisible by four, from its BCD digits.
    function automatic logic leap_year(input logic [7:0] y);
        logic [6:0] bin;
        bin = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
        return bin[1:0] == 2'b00;
    endfunction

    // Last BCD date of a month.
    function automatic logic [7:0] month_last_day(input logic [4:0] m,
                                                  input logic [7:0] y);
        logic [7:0] r;
        case (m)
            5'h02:                      r = leap_year(y) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tod_subsec_div.sv
module tod_subsec_div #(
    parameter int unsigned TICKS_PER_SEC = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic clr_i,
    output logic sec_evt_o
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        sec_evt_o = 1'b0;
        if (clr_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            if (cnt_q == LAST) begin
                cnt_d     = '0;
                sec_evt_o = 1'b1;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    AST_DIV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_q == '0));  // R8
    AST_DIV_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !clr_i) |=> $stable(cnt_q));  // R8

endmodule

// File: rtl/tod_hour_unit.sv
module tod_hour_unit (
    input  logic [6:0] hour_i,
    input  logic       adv_i,
    output logic [6:0] hour_o,
    output logic       day_o
);
    logic       mode12;
    logic       pm_d;
    logic [4:0] h12_d;
    logic [5:0] h24_d;

    assign mode12 = hour_i[6];

    always_comb begin
        hour_o = hour_i;
        day_o  = 1'b0;
        pm_d   = hour_i[5];
        h12_d  = hour_i[4:0];
        h24_d  = hour_i[5:0];
        if (adv_i) begin
            if (mode12) begin
                if (hour_i[4:0] == 5'h12) begin
                    h12_d = 5'h01;
                end else if (hour_i[4:0] == 5'h11) begin
                    h12_d = 5'h12;
                    pm_d  = ~hour_i[5];
                    day_o = hour_i[5];
                end else begin
                    h12_d = 5'(bcd_step_5(hour_i[4:0]));
                end
                hour_o = {1'b1, pm_d, h12_d};
            end else begin
                if (hour_i[5:0] == 6'h23) begin
                    h24_d = 6'h00;
                    day_o = 1'b1;
                end else begin
                    h24_d = bcd_step_6(hour_i[5:0]);
                end
                hour_o = {1'b0, h24_d};
            end
        end
    end

    function automatic logic [4:0] bcd_step_5(input logic [4:0] v);
        logic [7:0] w;
        w = tod_pkg::bcd_step({3'b000, v});
        return w[4:0];
    endfunction

    function automatic logic [5:0] bcd_step_6(input logic [5:0] v);
        logic [7:0] w;
        w = tod_pkg::bcd_step({2'b00, v});
        return w[5:0];
    endfunction

endmodule

// File: rtl/tod_date_unit.sv
module tod_date_unit (
    input  logic       adv_i,
    input  logic [7:0] dow_i,
    input  logic [7:0] date_i,
    input  logic [7:0] mon_i,
    input  logic [7:0] year_i,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o
);
    import tod_pkg::*;

    logic [7:0] last_day;
    logic       month_end;
    logic       year_end;

    assign last_day  = month_last_day(mon_i[4:0], year_i);
    assign month_end = (date_i == last_day);
    assign year_end  = month_end && (mon_i[4:0] == 5'h12);

    always_comb begin
        dow_o  = dow_i;
        date_o = date_i;
        mon_o  = mon_i;
        year_o = year_i;
        if (adv_i) begin
            dow_o = (dow_i == 8'h07) ? 8'h01 : bcd_step(dow_i);
            if (!month_end) begin
                date_o = bcd_step(date_i);
            end else begin
                date_o = 8'h01;
                if (!year_end) begin
                    mon_o = {mon_i[7], 2'b00, 5'(bcd_step({3'b000, mon_i[4:0]}))};
                end else begin
                    if (year_i == 8'h99) begin
                        year_o = 8'h00;
                        mon_o  = {~mon_i[7], 7'h01};
                    end else begin
                        year_o = bcd_step(year_i);
                        mon_o  = {mon_i[7], 7'h01};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tod_calendar.sv
module tod_calendar #(
    parameter int unsigned TICKS_PER_SEC = 1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic [2:0] rd_addr_i,
    output logic [7:0] rd_data_o
);
    import tod_pkg::*;

    localparam tod_regs_t RESET_VAL = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                        dow: 8'h01, date: 8'h01, mon: 8'h01,
                                        year: 8'h00};

    tod_regs_t  regs_d, regs_q;
    logic       sec_evt;
    logic       sec_clr;
    logic       sec_wrap, min_wrap;
    logic       hour_adv, day_adv;
    logic [6:0] hour_nxt;
    logic [7:0] dow_nxt, date_nxt, mon_nxt, year_nxt;

    assign sec_clr  = wr_en_i && (wr_addr_i == A_SEC);
    assign sec_wrap = (regs_q.sec == 8'h59);
    assign min_wrap = (regs_q.min == 8'h59);
    assign hour_adv = sec_evt && !wr_en_i && sec_wrap && min_wrap;

    tod_subsec_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) div_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .clr_i    (sec_clr),
        .sec_evt_o(sec_evt)
    );

    tod_hour_unit hour_i (
        .hour_i(regs_q.hour[6:0]),
        .adv_i (hour_adv),
        .hour_o(hour_nxt),
        .day_o (day_adv)
    );

    tod_date_unit date_i (
        .adv_i (day_adv),
        .dow_i (regs_q.dow),
        .date_i(regs_q.date),
        .mon_i (regs_q.mon),
        .year_i(regs_q.year),
        .dow_o (dow_nxt),
        .date_o(date_nxt),
        .mon_o (mon_nxt),
        .year_o(year_nxt)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            case (wr_addr_i)
                A_SEC:   regs_d.sec  = {1'b0, wr_data_i[6:0]};
                A_MIN:   regs_d.min  = {1'b0, wr_data_i[6:0]};
                A_HOUR:  regs_d.hour = {1'b0, wr_data_i[6:0]};
                A_DOW:   regs_d.dow  = {5'b0, wr_data_i[2:0]};
                A_DATE:  regs_d.date = {2'b0, wr_data_i[5:0]};
                A_MON:   regs_d.mon  = {wr_data_i[7], 2'b00, wr_data_i[4:0]};
                A_YEAR:  regs_d.year = wr_data_i;
                default: regs_d = regs_q;
            endcase
        end else if (sec_evt) begin
            regs_d.sec = sec_wrap ? 8'h00 : bcd_step(regs_q.sec);
            if (sec_wrap) begin
                regs_d.min = min_wrap ? 8'h00 : bcd_step(regs_q.min);
            end
            regs_d.hour = {1'b0, hour_nxt};
            regs_d.dow  = dow_nxt;
            regs_d.date = date_nxt;
            regs_d.mon  = mon_nxt;
            regs_d.year = year_nxt;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= RESET_VAL;
        else         regs_q <= regs_d;
    end

    always_comb begin
        case (rd_addr_i)
            A_SEC:   rd_data_o = regs_q.sec;
            A_MIN:   rd_data_o = regs_q.min;
            A_HOUR:  rd_data_o = regs_q.hour;
            A_DOW:   rd_data_o = regs_q.dow;
            A_DATE:  rd_data_o = regs_q.date;
            A_MON:   rd_data_o = regs_q.mon;
            A_YEAR:  rd_data_o = regs_q.year;
            default: rd_data_o = 8'h00;
        endcase
    end

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i && !sec_evt) |=> $stable(regs_q));  // R8
    AST_SEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sec_evt && !wr_en_i) |=> (regs_q.sec != $past(regs_q.sec)));  // R2
    AST_WRITE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == A_YEAR) |=> (regs_q.year == $past(wr_data_i)));  // R9
    AST_WRITE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i != A_SEC) |=> $stable(regs_q.sec));  // R9
    AST_MODE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(regs_q.hour[6]));  // R4
    AST_CENTURY_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i && sec_evt && regs_q.year == 8'h99 && regs_q.mon[4:0] == 5'h12
         && regs_q.date == 8'h31 && hour_adv && day_adv)
        |=> (regs_q.mon[7] != $past(regs_q.mon[7]) && regs_q.year == 8'h00));  // R7

endmodule

// File: tb/tod_calendar_tb.sv
module tod_calendar_tb_top;

    localparam int DIV = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       we = 1'b0;
    logic [2:0] wa = 3'd0;
    logic [7:0] wd = 8'h00;
    logic [2:0] ra = 3'd0;
    logic [7:0] rd;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // binary reference model
    int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_year, m_div;
    bit m_12, m_cent;

    always #10 clk = ~clk;

    tod_calendar #(.TICKS_PER_SEC(DIV)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(we),
        .wr_addr_i(wa), .wr_data_i(wd), .rd_addr_i(ra), .rd_data_o(rd)
    );

    function automatic logic [7:0] to_bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int from_bcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_in(int mon, int year);
        if (mon == 2) return (year % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] exp_byte(int a);
        int h;
        case (a)
            0: return to_bcd(m_sec);
            1: return to_bcd(m_min);
            2: begin
                if (!m_12) return to_bcd(m_hr);
                h = (m_hr % 12 == 0) ? 12 : m_hr % 12;
                return 8'h40 | ((m_hr >= 12) ? 8'h20 : 8'h00) | to_bcd(h);
            end
            3: return to_bcd(m_dow);
            4: return to_bcd(m_date);
            5: return {m_cent, 7'h00} | to_bcd(m_mon);
            6: return to_bcd(m_year);
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1;
        m_mon = 1; m_year = 0; m_div = 0; m_12 = 0; m_cent = 0;
    endtask

    task automatic model_second();
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_hr++;
        if (m_hr < 24) return;
        m_hr = 0;
        m_dow = (m_dow == 7) ? 1 : m_dow + 1;
        m_date++;
        if (m_date <= days_in(m_mon, m_year)) return;
        m_date = 1; m_mon++;
        if (m_mon <= 12) return;
        m_mon = 1; m_year++;
        if (m_year <= 99) return;
        m_year = 0; m_cent = ~m_cent;
    endtask

    task automatic model_write(int a, logic [7:0] d);
        int h;
        case (a)
            0: begin m_sec = from_bcd({1'b0, d[6:0]}); m_div = 0; end
            1: m_min = from_bcd({1'b0, d[6:0]});
            2: begin
                m_12 = d[6];
                if (d[6]) begin
                    h = from_bcd({3'b0, d[4:0]});
                    m_hr = (h % 12) + (d[5] ? 12 : 0);
                end else begin
                    m_hr = from_bcd({2'b0, d[5:0]});
                end
            end
            3: m_dow = int'(d[2:0]);
            4: m_date = from_bcd({2'b0, d[5:0]});
            5: begin m_cent = d[7]; m_mon = from_bcd({3'b0, d[4:0]}); end
            6: m_year = from_bcd(d);
            default: ;
        endcase
    endtask

    task automatic check_all(string tag);
        logic [7:0] e;
        for (int a = 0; a < 8; a++) begin
            ra = 3'(a);
            #1;
            e = exp_byte(a);
            total++;
            if (rd !== e) begin
                bad++;
                $display("FAIL %s addr=%0d got=%h exp=%h", tag, a, rd, e);
            end
        end
    endtask

    // one clock cycle of stimulus, then model update and full compare
    task automatic step(bit tk, bit w, int a, logic [7:0] d, string tag);
        bit evt;
        @(negedge clk);
        tick = tk; we = w; wa = 3'(a); wd = d;
        @(posedge clk);
        #1;
        evt = 1'b0;
        if (tk) begin
            if (m_div == DIV - 1) begin m_div = 0; evt = 1'b1; end
            else m_div++;
        end
        if (w) model_write(a, d);
        else if (evt) model_second();
        check_all(tag);
    endtask

    task automatic wr(int a, logic [7:0] d, string tag);
        step(1'b0, 1'b1, a, d, tag);
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 0, 8'h00, tag);
    endtask

    // legal random value for a register given current model state
    function automatic logic [7:0] rand_legal(int a);
        int v;
        bit hi;
        hi = ($urandom % 2) == 0;
        case (a)
            0, 1: begin v = hi ? 59 : int'($urandom % 60); return to_bcd(v); end
            2: begin
                v = hi ? 23 : int'($urandom % 24);
                if ($urandom % 2 == 0) return to_bcd(v);
                return 8'h40 | ((v >= 12) ? 8'h20 : 8'h00)
                       | to_bcd((v % 12 == 0) ? 12 : v % 12);
            end
            3: return to_bcd(hi ? 7 : int'($urandom % 7) + 1);
            4: begin
                v = days_in(m_mon, m_year);
                return to_bcd(hi ? v : int'($urandom % v) + 1);
            end
            5: begin
                if (m_date > 28) return {1'($urandom % 2), 7'h00} | to_bcd(hi ? 12 : 1);
                return {1'($urandom % 2), 7'h00} | to_bcd(hi ? 12 : int'($urandom % 12) + 1);
            end
            default: begin
                v = hi ? 99 : int'($urandom % 100);
                if (m_mon == 2 && m_date == 29) v = (v / 4) * 4;
                return to_bcd(v);
            end
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int seed_use;
        bit tk, w;
        int a;
        seed_use = int'($urandom(32'h5EC0_0D11));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset values");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_all("R1 after release");

        // R10: address 7 reads zero; R9: write to address 7 has no effect
        wr(7, 8'hFF, "R9 R10 unused address");

        // R8: divider, partial ticks do nothing; seconds write restarts count
        ticks(2, "R8 partial ticks");
        ticks(1, "R8 full second");
        ticks(2, "R8 partial again");
        wr(0, 8'h10, "R8 seconds write clears divider");
        ticks(2, "R8 restarted count");
        ticks(1, "R8 second after restart");

        // R2: minute and hour carry in 24-hour form
        wr(2, 8'h05, "R9 load hours");
        wr(1, 8'h59, "R9 load minutes");
        wr(0, 8'h58, "R9 load seconds");
        ticks(6, "R2 seconds minutes carry");

        // R3 and R5: 24-hour midnight, weekday wrap
        wr(3, 8'h07, "R5 load weekday");
        wr(2, 8'h23, "R3 load hour 23");
        wr(1, 8'h59, "R3 load minutes");
        wr(0, 8'h59, "R3 load seconds");
        ticks(3, "R3 R5 midnight 24h");

        // R4: 12-hour noon and midnight crossings
        wr(2, 8'h51, "R4 load 11 AM");
        wr(1, 8'h59, "R4 load minutes");
        wr(0, 8'h59, "R4 load seconds");
        ticks(3, "R4 11 AM to 12 PM");
        wr(1, 8'h59, "R4 load minutes");
        wr(0, 8'h59, "R4 load seconds");
        ticks(3, "R4 12 PM to 1 PM");
        wr(2, 8'h71, "R4 load 11 PM");
        wr(1, 8'h59, "R4 load minutes");
        wr(0, 8'h59, "R4 load seconds");
        ticks(3, "R4 R5 11 PM to 12 AM new day");

        // R6: month lengths
        wr(2, 8'h23, "R6 load hour");
        wr(6, 8'h23, "R6 common year");
        wr(5, 8'h02, "R6 Feb");
        wr(4, 8'h28, "R6 date 28");
        wr(1, 8'h59, "R6 minutes");
        wr(0, 8'h59, "R6 seconds");
        ticks(3, "R6 Feb 28 common to Mar 1");
        wr(2, 8'h23, "R6 load hour");
        wr(6, 8'h24, "R6 leap year");
        wr(5, 8'h02, "R6 Feb");
        wr(4, 8'h28, "R6 date 28");
        wr(1, 8'h59, "R6 minutes");
        wr(0, 8'h59, "R6 seconds");
        ticks(3, "R6 Feb 28 leap to Feb 29");
        wr(2, 8'h23, "R6 load hour");
        wr(1, 8'h59, "R6 minutes");
        wr(0, 8'h59, "R6 seconds");
        ticks(3, "R6 Feb 29 to Mar 1");
        wr(2, 8'h23, "R6 load hour");
        wr(5, 8'h04, "R6 Apr");
        wr(4, 8'h30, "R6 date 30");
        wr(1, 8'h59, "R6 minutes");
        wr(0, 8'h59, "R6 seconds");
        ticks(3, "R6 Apr 30 to May 1");

        // R7: year and century wrap
        wr(2, 8'h23, "R7 load hour");
        wr(6, 8'h99, "R7 year 99");
        wr(5, 8'h12, "R7 Dec century 0");
        wr(4, 8'h31, "R7 date 31");
        wr(1, 8'h59, "R7 minutes");
        wr(0, 8'h59, "R7 seconds");
        ticks(3, "R7 century flip");
        wr(5, 8'h92, "R7 Dec century 1");
        wr(4, 8'h31, "R7 date 31");
        wr(6, 8'h41, "R7 year 41");
        wr(2, 8'h23, "R7 load hour");
        wr(1, 8'h59, "R7 minutes");
        wr(0, 8'h59, "R7 seconds");
        ticks(3, "R7 year advance keeps century");

        // R9: write coinciding with a second event drops the event
        wr(0, 8'h20, "R9 seconds");
        ticks(2, "R9 partial");
        step(1'b1, 1'b1, 1, 8'h33, "R9 write beats tick");
        ticks(3, "R9 counting resumes");

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            tk = ($urandom % 4) != 0;
            w  = ($urandom % 40) == 0;
            a  = int'($urandom % 7);
            step(tk, w, a, w ? rand_legal(a) : 8'h00, "R2 R9 random");
        end
        @(negedge clk);
        tick = 1'b0; we = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule